// File: doc/BRIEF.md
# Energy-Based Voice Activity Detector

This block decides whether a stream of signed PCM samples carries speech-level energy. Each accepted sample is turned into a magnitude, and that magnitude feeds a leaky (first-order) averager. The averager rises quickly when the signal grows and falls slowly when the signal goes quiet. The averaged level is compared with a programmable threshold to produce a single activity flag.

The rise rate and the fall rate are set by two separate shift amounts. A small rise shift and a large fall shift give a detector that reacts within a few milliseconds and holds for around a hundred milliseconds. The integer part of the averaged level is driven onto an output at all times. Software can watch this level during silence and place the threshold just above the noise floor.

The block is a plain sample-driven datapath. Nothing moves unless the sample strobe is high.

Top module: `vad_energy_detector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator and the `vad_active` flag are cleared, so `energy` reads 0 and `vad_active` reads 0.
- R2: Rectification gives the absolute value of the two's-complement sample. The most negative code (only the MSB set) saturates to the largest positive magnitude, 2^(SAMPLE_W-1)-1.
- R3: The accumulator holds FRAC_W fractional bits below a MAG_W-bit integer part. When the scaled magnitude (magnitude shifted left by FRAC_W) is greater than the accumulator, the update is acc = acc + ((mag_scaled - acc) >> atk_shift).
- R4: When the scaled magnitude is less than or equal to the accumulator, the update is acc = acc + ((mag_scaled - acc) >>> dcy_shift). The shift is arithmetic, so the step rounds toward minus infinity and a nonzero gap always moves the level by at least one fractional LSB.
- R5: On each accepted sample, `vad_active` becomes 1 when the updated `energy` is strictly greater than `thresh`, and 0 when it is less than or equal to it. `thresh` is sampled at the same edge.
- R6: When `smp_valid` is low, `energy` and `vad_active` keep their values, whatever happens on `smp_data`, `thresh` or the shift inputs.
- R7: The rise and fall rates are independent. With `atk_shift`=0 the level jumps straight to a louder magnitude, while a nonzero `dcy_shift` governs only the falling steps.
- R8: `energy` is the integer part (the upper MAG_W bits) of the accumulator. It and `vad_active` change at the clock edge that accepts the sample, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe: accept `smp_data` at this edge |
| smp_data | input | SAMPLE_W | Signed PCM sample |
| thresh | input | SAMPLE_W-1 | Activity threshold, compared with `energy` |
| atk_shift | input | SHIFT_W | Right-shift applied to rising steps |
| dcy_shift | input | SHIFT_W | Right-shift applied to falling steps |
| vad_active | output | 1 | 1 while the averaged energy is above the threshold |
| energy | output | SAMPLE_W-1 | Integer part of the averaged energy |

## Verification
The bound checker watches four things on every cycle. It checks that both outputs hold while no sample is accepted. It checks that the flag agrees with a strict comparison of the new level against the threshold captured at the accepting edge. It also checks the direction rules of the averager: a louder input never lowers the level and never overshoots the magnitude, and a quieter input never raises the level and never undershoots the magnitude.

Only the bench scenarios can show the exact arithmetic. These cover the precise step sizes under each shift, the rounding of falling steps, saturation of the most negative code, the equal-to-threshold case and the reset values. They compare every accepted sample against a reference computation of the update rule.

// File: rtl/vad_pkg.sv
// Package: shared types of the voice activity detector.
// Assumes nothing beyond IEEE 1800-2017 typing.
package vad_pkg;

    // Which time constant the integrator applies on this update.
    typedef enum logic {
        VAD_DIR_FALL = 1'b0,
        VAD_DIR_RISE = 1'b1
    } vad_dir_e;

endpackage : vad_pkg

// File: rtl/vad_rectify.sv
// Module: vad_rectify
// Converts a signed two's-complement sample into an unsigned magnitude
// one bit narrower. The single code that has no positive twin (MSB set,
// all other bits clear) is clamped to the all-ones magnitude.
// Assumes: SAMPLE_W >= 2. Purely combinational.
module vad_rectify #(
    parameter int SAMPLE_W = 16,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic [MAG_W-1:0]    magnitude
);

    logic                is_neg;
    logic                is_most_neg;
    logic [SAMPLE_W-1:0] negated;

    // Decode sign, detect the unrepresentable magnitude, form the negation.
    always_comb begin
        is_neg      = sample[SAMPLE_W-1];
        is_most_neg = is_neg && (sample[MAG_W-1:0] == '0);
        negated     = (~sample) + {{(SAMPLE_W-1){1'b0}}, 1'b1};
    end

    // Select the magnitude, saturating the most negative code.
    always_comb begin
        if (is_most_neg) begin
            magnitude = '1;
        end else if (is_neg) begin
            magnitude = negated[MAG_W-1:0];
        end else begin
            magnitude = sample[MAG_W-1:0];
        end
    end

endmodule : vad_rectify

// File: rtl/vad_integrator.sv
// Module: vad_integrator
// Lossy first-order averager with separate rise and fall shifts:
//   acc <= acc + ((mag << FRAC_W) - acc) >>> k
// k is rise_shift when the scaled magnitude exceeds acc, else fall_shift.
// Also presents the next value (acc_next) so a follower can register a
// decision taken on the updated level in the same cycle.
// Assumes: the update cannot leave [0, mag<<FRAC_W] hull, so no overflow.
module vad_integrator
    import vad_pkg::*;
#(
    parameter int MAG_W   = 15,
    parameter int FRAC_W  = 8,
    parameter int SHIFT_W = 4,
    localparam int ACC_W  = MAG_W + FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic [MAG_W-1:0]   mag,
    input  logic [SHIFT_W-1:0] rise_shift,
    input  logic [SHIFT_W-1:0] fall_shift,
    output logic [ACC_W-1:0]   acc_q,
    output logic [ACC_W-1:0]   acc_next
);

    logic [ACC_W-1:0]        mag_scaled;
    vad_dir_e                dir;
    logic [SHIFT_W-1:0]      k;
    logic signed [ACC_W:0]   mag_x;
    logic signed [ACC_W:0]   acc_x;
    logic signed [ACC_W:0]   gap;
    logic signed [ACC_W:0]   step;
    logic signed [ACC_W:0]   sum;

    // Align the magnitude with the accumulator's binary point.
    always_comb begin
        mag_scaled = {mag, {FRAC_W{1'b0}}};
        mag_x      = {1'b0, mag_scaled};
        acc_x      = {1'b0, acc_q};
    end

    // Choose the time constant from the direction of travel.
    always_comb begin
        dir = (mag_scaled > acc_q) ? VAD_DIR_RISE : VAD_DIR_FALL;
        k   = (dir == VAD_DIR_RISE) ? rise_shift : fall_shift;
    end

    // Signed gap, arithmetic shift (floors toward minus infinity), new level.
    always_comb begin
        gap      = mag_x - acc_x;
        step     = gap >>> k;
        sum      = acc_x + step;
        acc_next = sum[ACC_W-1:0];
    end

    // Accumulator register: cleared on reset, advanced on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (upd) begin
            acc_q <= acc_next;
        end
    end

endmodule : vad_integrator

// File: rtl/vad_compare.sv
// Module: vad_compare
// Registers the activity decision: set when the level strictly exceeds
// the threshold, cleared otherwise (equality counts as inactive).
// Assumes: level and threshold share the same integer scaling.
module vad_compare #(
    parameter int MAG_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [MAG_W-1:0] level,
    input  logic [MAG_W-1:0] limit,
    output logic             active_q
);

    logic above;

    // Strict comparison of level against limit.
    always_comb begin
        above = (level > limit);
    end

    // Flag register: cleared on reset, refreshed on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (upd) begin
            active_q <= above;
        end
    end

endmodule : vad_compare

// File: rtl/vad_energy_detector.sv
// Module: vad_energy_detector (top)
// Voice activity detector: rectify -> lossy integrate -> threshold.
// The integer part of the integrator is exported as the energy level.
// Assumes: one sample per smp_valid strobe; inputs synchronous to clk;
// synchronous active-low reset.
module vad_energy_detector #(
    parameter int SAMPLE_W = 16,
    parameter int FRAC_W   = 8,
    parameter int SHIFT_W  = 4,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [MAG_W-1:0]    thresh,
    input  logic [SHIFT_W-1:0]  atk_shift,
    input  logic [SHIFT_W-1:0]  dcy_shift,
    output logic                vad_active,
    output logic [MAG_W-1:0]    energy
);

    localparam int ACC_W = MAG_W + FRAC_W;

    logic [MAG_W-1:0] rect_mag;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;
    logic [MAG_W-1:0] level_next;

    vad_rectify #(
        .SAMPLE_W (SAMPLE_W)
    ) u_rectify (
        .sample    (smp_data),
        .magnitude (rect_mag)
    );

    vad_integrator #(
        .MAG_W   (MAG_W),
        .FRAC_W  (FRAC_W),
        .SHIFT_W (SHIFT_W)
    ) u_integrator (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (smp_valid),
        .mag        (rect_mag),
        .rise_shift (atk_shift),
        .fall_shift (dcy_shift),
        .acc_q      (acc_q),
        .acc_next   (acc_next)
    );

    // Integer parts of the present and next accumulator values.
    always_comb begin
        level_next = acc_next[ACC_W-1:FRAC_W];
        energy     = acc_q[ACC_W-1:FRAC_W];
    end

    vad_compare #(
        .MAG_W (MAG_W)
    ) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (smp_valid),
        .level    (level_next),
        .limit    (thresh),
        .active_q (vad_active)
    );

endmodule : vad_energy_detector

// File: rtl/vad_energy_detector_chk.sv
// Module: vad_energy_detector_chk
// Property checker bound into vad_energy_detector. Observes ports and the
// rectifier output; drives nothing.
module vad_energy_detector_chk #(
    parameter int SAMPLE_W = 16,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [MAG_W-1:0] thresh,
    input logic [MAG_W-1:0] rect_mag,
    input logic [MAG_W-1:0] energy,
    input logic             vad_active
);

    AST_ENERGY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(energy)); // R6

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(vad_active)); // R6

    AST_FLAG_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (vad_active == (energy > $past(thresh)))); // R5

    AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (rect_mag >= energy)) |=>
            ((energy >= $past(energy)) && (energy <= $past(rect_mag)))); // R3

    AST_FALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (rect_mag < energy)) |=>
            ((energy <= $past(energy)) && (energy >= $past(rect_mag)))); // R4

endmodule : vad_energy_detector_chk

bind vad_energy_detector vad_energy_detector_chk #(
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .thresh     (thresh),
    .rect_mag   (rect_mag),
    .energy     (energy),
    .vad_active (vad_active)
);

// File: tb/tb_vad_energy_detector.sv
module tb_vad_energy_detector;

    localparam int SAMPLE_W = 16;
    localparam int FRAC_W   = 8;
    localparam int SHIFT_W  = 4;
    localparam int MAG_W    = SAMPLE_W - 1;

    typedef struct {
        longint exp_energy;
        bit     exp_flag;
        string  tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic [SAMPLE_W-1:0] smp_data = '0;
    logic [MAG_W-1:0]    thresh = '0;
    logic [SHIFT_W-1:0]  atk_shift = '0;
    logic [SHIFT_W-1:0]  dcy_shift = '0;
    logic                vad_active;
    logic [MAG_W-1:0]    energy;

    int     n_checks = 0;
    int     n_fail   = 0;
    longint model_acc = 0;
    exp_t   sb_q[$];

    vad_energy_detector #(
        .SAMPLE_W (SAMPLE_W),
        .FRAC_W   (FRAC_W),
        .SHIFT_W  (SHIFT_W)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .thresh     (thresh),
        .atk_shift  (atk_shift),
        .dcy_shift  (dcy_shift),
        .vad_active (vad_active),
        .energy     (energy)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: applies one sample and pushes the expected result.
    task automatic send(input int s, input int thr, input string tag);
        longint mag;
        longint scaled;
        longint gap;
        int     k;
        exp_t   e;
        @(negedge clk);
        smp_data  = SAMPLE_W'(s);
        thresh    = MAG_W'(thr);
        smp_valid = 1'b1;
        mag = (s < 0) ? -longint'(s) : longint'(s);
        if (mag > (1 << (SAMPLE_W - 1)) - 1) mag = (1 << (SAMPLE_W - 1)) - 1;
        scaled = mag << FRAC_W;
        k   = (scaled > model_acc) ? int'(atk_shift) : int'(dcy_shift);
        gap = scaled - model_acc;
        model_acc = model_acc + (gap >>> k);
        e.exp_energy = model_acc >> FRAC_W;
        e.exp_flag   = (e.exp_energy > thr);
        e.tag        = tag;
        sb_q.push_back(e);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Idle cycles with disturbed inputs; outputs must not move.
    task automatic idle_disturb(input int cycles, input int thr);
        logic [MAG_W-1:0] e0;
        logic             f0;
        @(negedge clk);
        e0 = energy;
        f0 = vad_active;
        for (int i = 0; i < cycles; i++) begin
            smp_data  = SAMPLE_W'(12345 + i);
            thresh    = MAG_W'(thr);
            atk_shift = SHIFT_W'(i);
            @(negedge clk);
        end
        check("R6 energy held", energy, e0);
        check("R6 flag held", vad_active, f0);
    endtask

    // Monitor: pops the expected item after each accepting edge.
    initial begin
        forever begin
            @(posedge clk);
            if (smp_valid && rst_n) begin
                exp_t e;
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    check("scoreboard underflow", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check({e.tag, " energy"}, energy, e.exp_energy);
                    check({e.tag, " flag"}, vad_active, e.exp_flag);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 energy after reset", energy, 0);
        check("R1 flag after reset", vad_active, 0);
        rst_n = 1'b1;

        // R2/R8: shift 0 makes energy equal the rectified magnitude.
        atk_shift = 0; dcy_shift = 0;
        send(100, 50, "R2 positive");
        send(-200, 50, "R2 negative");
        send(-32768, 100, "R2 most negative saturates");
        send(32767, 100, "R2 max positive");
        send(0, 0, "R8 zero level");

        // R5: equality is inactive, one below is active.
        send(500, 500, "R5 equal threshold");
        send(500, 499, "R5 above threshold");
        send(500, 501, "R5 below threshold");

        // R3: gradual rise with attack shift 2.
        atk_shift = 2; dcy_shift = 0;
        send(0, 0, "R3 clear");
        for (int i = 0; i < 6; i++) send(1000, 900, "R3 rise");

        // R4: slow fall with decay shift 6, including floor rounding.
        atk_shift = 0; dcy_shift = 6;
        send(1000, 0, "R4 preset");
        for (int i = 0; i < 8; i++) send(-3, 950, "R4 fall");

        // R7: instant rise, governed fall.
        atk_shift = 0; dcy_shift = 4;
        send(0, 0, "R7 start");
        send(-1000, 990, "R7 instant rise");
        send(0, 990, "R7 governed fall");
        send(0, 900, "R7 governed fall 2");

        // R6: no accepted samples while inputs wander.
        idle_disturb(10, 0);
        idle_disturb(5, 32767);

        // Reset during activity.
        send(20000, 10, "R7 loud");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 energy cleared", energy, 0);
        check("R1 flag cleared", vad_active, 0);
        model_acc = 0;
        rst_n = 1'b1;
        send(7, 0, "R3 after reset");

        repeat (3) @(negedge clk);
        check("scoreboard drained", sb_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule : tb_vad_energy_detector